// File: doc/BRIEF.md
# Serial Port Register Front End with Interrupt Request

This block is the register face of a 16550-style serial port, seen from a byte-wide processor bus. It holds the baud divisor, the line format, the modem control, interrupt enable, FIFO control and scratch registers. It reports line status, modem status and interrupt identity, and it produces one interrupt request. Bit timing, the baud generator and real FIFOs are left to neighbouring logic.

Received bytes come in on a valid/ready byte stream, and a read of the data register pops one of them. Transmitted bytes leave as a one-cycle valid pulse with the byte. A loopback mode in modem control sends written bytes back into the receive path, so software can test itself without a line. The line control word is decoded into a data length, a stop-bit mode, a parity mode and a break request, and these drive the serializer. A bus address is divided by a parameter stride before the eight registers are decoded.

Top module: `uart_regs_front`

## Requirements
- R1: After reset the divisor is 12, the line control register reads 0x03 (8 data bits, no parity, one stop bit, divisor access off), the interrupt enable, modem control and FIFO control registers read 0, and irq is low.
- R2: The register offset is the bus address divided by STRIDE. Offset 7 is a read/write scratch byte. Offsets 8 and above read 0, and writes to them change nothing.
- R3: While line control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the high byte. In that state no byte is transmitted, the interrupt enable register is untouched and no received byte is popped.
- R4: Line control bits [1:0] give 5 to 8 data bits. stop_mode is 0 (one stop bit) when bit 2 is clear. When bit 2 is set it is 1 (one and a half) for the 5-bit length and 2 (two) otherwise.
- R5: Line control bits [5:3] give parity_mode 0 none for code 0, 1 odd for code 1, 2 even for code 3, 3 forced zero for code 5 and 4 forced one for code 7. Codes 2, 4 and 6 give 7 (undefined). Bit 6 drives break_req.
- R6: A write to offset 2 loads FIFO control. A read of offset 2 returns identification: bit 0 is set when nothing is pending, bit 1 is transmit-ready pending, bit 2 is receive data available, bits [5:3] are 0 and, in FIFO mode, bits [7:6] equal FIFO control bits [2:1].
- R7: A data write with bit 7 clear and loopback off pulses tx_valid for one cycle with the byte, starting the cycle after the write. Every data write sets the transmit-ready pending flag. A read of the identification register clears that flag.
- R8: With modem control bit 4 (loopback) set, a data write produces no tx_valid pulse. The byte becomes receive data and is read back before any byte on the receive stream.
- R9: A write to offset 1 that sets interrupt enable bit 1 while it was clear sets the transmit-ready pending flag. A write that leaves the bit set does not.
- R10: An interrupt is pending when (enable bit 1 and transmit-ready pending) or (enable bit 0 and receive data available). irq is high only when an interrupt is pending and modem control bit 3 is set.
- R11: Line status (offset 5) reads 0x60 with bit 0 set while receive data is available. Modem status (offset 6) reads 0xB0. Writes to both are ignored.
- R12: A read of offset 0 with bit 7 clear returns the next received byte and asserts rx_ready to the stream in that same cycle, except when it is served by a loopback byte. With no byte available it returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address, divided by STRIDE |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte taken this cycle |
| tx_valid | output | 1 | Transmit byte pulse |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |
| divisor | output | 16 | Baud divisor |
| data_bits | output | 4 | Character length, 5 to 8 |
| stop_mode | output | 2 | 0 one, 1 one and a half, 2 two stop bits |
| parity_mode | output | 3 | 0 none, 1 odd, 2 even, 3 zero, 4 one, 7 undefined |
| break_req | output | 1 | Break requested |

## Verification
The hardest state to reach is the transmit-ready pending flag on its own, because reading the identification register, which is the only way to see the flag, also clears it. The stimulus reads twice in a row, so the first read shows the flag and the second proves it was cleared. It sets the flag both by a data write and by toggling the transmit enable bit from clear to set, and it shows that writing the bit again while it is already set does not set the flag. Loopback ordering is reached by holding a byte on the receive stream while a loopback byte is written, and then checking that rx_ready stays low on the first read.

// File: rtl/uart_regs_front.sv
module uart_regs_front #(
  parameter int ADDR_W = 6,
  parameter int STRIDE = 4,
  parameter bit FIFO_MODE = 1'b1,
  parameter logic [15:0] DIV_RESET = 16'd12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq,
  output logic [15:0]       divisor,
  output logic [3:0]        data_bits,
  output logic [1:0]        stop_mode,
  output logic [2:0]        parity_mode,
  output logic              break_req
);

  localparam int NREG = 8;

  logic [ADDR_W-1:0] ofs;
  logic [2:0] idx;
  logic hit, wr_en, rd_en;
  logic [7:0] lcr_q, mcr_q, ier_q, fcr_q, scr_q;
  logic thr_pend, lb_valid;
  logic [7:0] lb_data;
  logic dlab, loopback, rx_avail, pending;
  logic data_wr, data_rd, ier_wr, iir_rd;
  logic [7:0] rx_byte, iir, lsr;

  assign ofs   = ADDR_W'(bus_addr / ADDR_W'(STRIDE));
  assign idx   = ofs[2:0];
  assign hit   = bus_sel && (ofs < ADDR_W'(NREG));
  assign wr_en = hit && bus_wr;
  assign rd_en = hit && !bus_wr;

  assign dlab     = lcr_q[7];
  assign loopback = mcr_q[4];
  assign rx_avail = lb_valid || rx_valid;
  assign rx_byte  = lb_valid ? lb_data : (rx_valid ? rx_data : 8'h00);
  assign pending  = (ier_q[1] && thr_pend) || (ier_q[0] && rx_avail);
  assign irq      = pending && mcr_q[3];

  assign data_wr = wr_en && idx == 3'd0 && !dlab;
  assign data_rd = rd_en && idx == 3'd0 && !dlab;
  assign ier_wr  = wr_en && idx == 3'd1 && !dlab;
  assign iir_rd  = rd_en && idx == 3'd2;
  assign rx_ready = data_rd && !lb_valid && rx_valid;

  assign iir = {(FIFO_MODE ? fcr_q[2:1] : 2'b00), 3'b000, rx_avail, thr_pend, !pending};
  assign lsr = {1'b0, 1'b1, 1'b1, 4'b0000, rx_avail};

  always_comb begin
    bus_rdata = 8'h00;
    if (rd_en) begin
      case (idx)
        3'd0: bus_rdata = dlab ? divisor[7:0] : rx_byte;
        3'd1: bus_rdata = dlab ? divisor[15:8] : ier_q;
        3'd2: bus_rdata = iir;
        3'd3: bus_rdata = lcr_q;
        3'd4: bus_rdata = mcr_q;
        3'd5: bus_rdata = lsr;
        3'd6: bus_rdata = 8'hB0;
        default: bus_rdata = scr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divisor <= DIV_RESET;
      lcr_q   <= 8'h03;
      mcr_q   <= 8'h00;
      ier_q   <= 8'h00;
      fcr_q   <= 8'h00;
      scr_q   <= 8'h00;
    end else if (wr_en) begin
      case (idx)
        3'd0: if (dlab) divisor[7:0] <= bus_wdata;
        3'd1: if (dlab) divisor[15:8] <= bus_wdata; else ier_q <= bus_wdata;
        3'd2: fcr_q <= bus_wdata;
        3'd3: lcr_q <= bus_wdata;
        3'd4: mcr_q <= bus_wdata;
        3'd7: scr_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_pend <= 1'b0;
      lb_valid <= 1'b0;
      lb_data  <= 8'h00;
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
    end else begin
      tx_valid <= data_wr && !loopback;
      if (data_wr && !loopback) tx_data <= bus_wdata;
      if (data_wr && loopback) begin
        lb_valid <= 1'b1;
        lb_data  <= bus_wdata;
      end else if (data_rd) begin
        lb_valid <= 1'b0;
      end
      if (data_wr || (ier_wr && !ier_q[1] && bus_wdata[1])) thr_pend <= 1'b1;
      else if (iir_rd) thr_pend <= 1'b0;
    end
  end

  always_comb begin
    data_bits = 4'd5 + {2'b00, lcr_q[1:0]};
    if (!lcr_q[2]) stop_mode = 2'd0;
    else if (lcr_q[1:0] == 2'b00) stop_mode = 2'd1;
    else stop_mode = 2'd2;
    case (lcr_q[5:3])
      3'd0: parity_mode = 3'd0;
      3'd1: parity_mode = 3'd1;
      3'd3: parity_mode = 3'd2;
      3'd5: parity_mode = 3'd3;
      3'd7: parity_mode = 3'd4;
      default: parity_mode = 3'd7;
    endcase
  end
  assign break_req = lcr_q[6];

  // R3: a data-offset write under divisor access never transmits
  a_r3_dlab_no_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 3'd0 && dlab) |=> !tx_valid);

  // R3: divisor changes only through divisor-access writes
  a_r3_div_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && dlab && (idx == 3'd0 || idx == 3'd1)) |=> $stable(divisor));

  // R7: any data write leaves transmit-ready pending
  a_r7_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> thr_pend);

  // R8: loopback writes go to the receive side, not the transmitter
  a_r8_loop: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && loopback) |=> (!tx_valid && lb_valid));

  // R10: request rises only with the modem-control gate open
  a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> mcr_q[3]);

  // R12: stream byte is never taken while a loopback byte is held
  a_r12_lb_first: assert property (@(posedge clk) disable iff (!rst_n)
    lb_valid |-> !rx_ready);

endmodule

// File: tb/uart_regs_front_test.sv
module uart_regs_front_test;
  localparam time CLK_PERIOD = 10;
  localparam int STRIDE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready, tx_valid, irq, break_req;
  logic [7:0] tx_data;
  logic [15:0] divisor;
  logic [3:0] data_bits;
  logic [1:0] stop_mode;
  logic [2:0] parity_mode;

  int checks = 0, fails = 0, cycles = 0;
  logic last_ready;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regs_front #(.ADDR_W(6), .STRIDE(STRIDE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq), .divisor(divisor),
    .data_bits(data_bits), .stop_mode(stop_mode), .parity_mode(parity_mode),
    .break_req(break_req));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_addr(input logic [5:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input int o, input logic [7:0] v);
    wr_addr(6'(o * STRIDE), v);
  endtask

  task automatic rd_addr(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    v = bus_rdata;
    last_ready = rx_ready;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd(input int o, output logic [7:0] v);
    rd_addr(6'(o * STRIDE), v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 divisor", divisor, 16'd12);
    check("R1 irq", irq, 1'b0);
    rd(3, v); check("R1 lcr", v, 8'h03);
    rd(1, v); check("R1 ier", v, 8'h00);
    rd(4, v); check("R1 mcr", v, 8'h00);
    check("R1 bits", data_bits, 4'd8);
    check("R1 parity", parity_mode, 3'd0);
    check("R1 stop", stop_mode, 2'd0);
    rd(2, v); check("R1 fcr via iir", v, 8'h01);
  endtask

  task automatic t_addr();
    logic [7:0] v;
    wr(7, 8'h5A);
    rd(7, v); check("R2 scratch", v, 8'h5A);
    rd_addr(6'd29, v); check("R2 stride division", v, 8'h5A);
    wr(9, 8'hFF);
    rd(9, v); check("R2 out of map read", v, 8'h00);
    rd(7, v); check("R2 out of map write ignored", v, 8'h5A);
  endtask

  task automatic t_dlab();
    logic [7:0] v;
    wr(3, 8'h83);
    wr(0, 8'h34);
    check("R3 no tx under dlab", tx_valid, 1'b0);
    wr(1, 8'h12);
    check("R3 divisor", divisor, 16'h1234);
    rx_valid = 1'b1; rx_data = 8'h77;
    rd(0, v); check("R3 low read", v, 8'h34);
    check("R3 no pop", last_ready, 1'b0);
    rd(1, v); check("R3 high read", v, 8'h12);
    rx_valid = 1'b0;
    wr(3, 8'h03);
    rd(1, v); check("R3 ier untouched", v, 8'h00);
    check("R3 divisor kept", divisor, 16'h1234);
  endtask

  task automatic t_lcr();
    wr(3, 8'h00); check("R4 5 bits", data_bits, 4'd5); check("R4 stop 1", stop_mode, 2'd0);
    wr(3, 8'h04); check("R4 stop 1.5", stop_mode, 2'd1);
    wr(3, 8'h07); check("R4 8 bits", data_bits, 4'd8); check("R4 stop 2", stop_mode, 2'd2);
    wr(3, 8'h0D); check("R4 6 bits", data_bits, 4'd6); check("R4 stop 2 six", stop_mode, 2'd2);
    check("R5 odd", parity_mode, 3'd1);
    wr(3, 8'h1B); check("R5 even", parity_mode, 3'd2);
    wr(3, 8'h2A); check("R5 zero", parity_mode, 3'd3); check("R4 7 bits", data_bits, 4'd7);
    wr(3, 8'h3B); check("R5 one", parity_mode, 3'd4);
    wr(3, 8'h13); check("R5 undefined", parity_mode, 3'd7);
    wr(3, 8'h43); check("R5 break", break_req, 1'b1); check("R5 none", parity_mode, 3'd0);
    wr(3, 8'h03); check("R5 break off", break_req, 1'b0);
  endtask

  task automatic t_fifo();
    logic [7:0] v;
    wr(2, 8'h06);
    rd(2, v); check("R6 fifo bits 11", v, 8'hC1);
    wr(2, 8'h02);
    rd(2, v); check("R6 fifo bits 01", v, 8'h41);
    wr(2, 8'h00);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    wr_addr(6'd0, 8'h41);
    check("R7 tx_valid", tx_valid, 1'b1);
    check("R7 tx_data", tx_data, 8'h41);
    @(negedge clk);
    check("R7 single pulse", tx_valid, 1'b0);
    rd(2, v); check("R7 pending shown", v, 8'h03);
    rd(2, v); check("R7 cleared by read", v, 8'h01);
  endtask

  task automatic t_loop();
    logic [7:0] v;
    wr(4, 8'h10);
    rx_valid = 1'b1; rx_data = 8'h99;
    wr(0, 8'hA5);
    check("R8 no tx", tx_valid, 1'b0);
    rd(0, v); check("R8 loop byte first", v, 8'hA5);
    check("R12 stream not popped", last_ready, 1'b0);
    rd(0, v); check("R12 stream byte", v, 8'h99);
    check("R12 pop", last_ready, 1'b1);
    rx_valid = 1'b0;
    rd(0, v); check("R12 empty reads 0", v, 8'h00);
    rd(2, v);
    wr(4, 8'h00);
  endtask

  task automatic t_ier_edge();
    logic [7:0] v;
    wr(1, 8'h02);
    rd(2, v); check("R9 rise sets pending", v, 8'h02);
    rd(2, v); check("R9 read clears", v, 8'h01);
    wr(1, 8'h02);
    rd(2, v); check("R9 no rise no set", v, 8'h01);
    wr(1, 8'h00);
    wr(1, 8'h02);
    rd(2, v); check("R9 second rise", v, 8'h02);
    wr(1, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(1, 8'h01);
    rx_valid = 1'b1; rx_data = 8'h11;
    #1 check("R10 gate closed", irq, 1'b0);
    wr(4, 8'h08);
    check("R10 irq on", irq, 1'b1);
    rd(2, v); check("R10 iir rx", v, 8'h04);
    rx_valid = 1'b0;
    #1 check("R10 irq off", irq, 1'b0);
    wr(0, 8'h22);
    check("R10 tx pending not enabled", irq, 1'b0);
    wr(1, 8'h03);
    check("R10 tx enabled", irq, 1'b1);
    rd(2, v);
    check("R10 cleared", irq, 1'b0);
    wr(1, 8'h00); wr(4, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] v;
    rd(5, v); check("R11 lsr idle", v, 8'h60);
    rx_valid = 1'b1;
    rd(5, v); check("R11 lsr ready", v, 8'h61);
    rx_valid = 1'b0;
    wr(5, 8'h00);
    rd(5, v); check("R11 lsr write ignored", v, 8'h60);
    wr(6, 8'h00);
    rd(6, v); check("R11 msr", v, 8'hB0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr();
    t_dlab();
    t_lcr();
    t_fifo();
    t_tx();
    t_loop();
    t_ier_edge();
    t_irq();
    t_status();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule